// File: doc/BRIEF.md
# Charge-break measurement timing sequencer

This block turns a slow oscillator tick (nominally 800 Hz, one clock-wide enable) into a repeating charge and measurement schedule. Every period is made of a long charging phase followed by a currentless break. The break opens with a settling delay, during which the battery voltage recovers. The rest of the break is a measurement window for an external voltage converter.

A short synchronisation pulse is placed a fixed offset into the break, for use by outside test equipment. When the measurement window closes, a one-clock strobe tells the downstream decision logic that a fresh reading is complete.

All durations are counted in ticks and are parameters. The defaults give a 20.48 s period with a 2.56 s break at 800 Hz. The outputs are a combinational decode of one registered position counter. The end strobe is registered.

Top module: `charge_break_sequencer`

## Requirements
- R1: A synchronous reset sets the position to zero. While reset is applied, and after it is released, charge_on is 1 and measure_window, sync_pulse and cycle_done are 0, until the next tick arrives.
- R2: The position advances by one only on a clock in which tick_800hz is 1. In any clock without a tick, charge_on, measure_window and sync_pulse keep their values.
- R3: Positions run from 0 to CYCLE_TICKS-1 and then wrap to 0, so the schedule repeats every CYCLE_TICKS ticks.
- R4: charge_on is 1 for positions 0 to CYCLE_TICKS-BREAK_TICKS-1. It is 0 for the last BREAK_TICKS positions of the period (the break).
- R5: measure_window is 1 only for break offsets SETTLE_TICKS to BREAK_TICKS-1, where the break offset is the position minus (CYCLE_TICKS-BREAK_TICKS). It is 0 for the whole settling delay.
- R6: sync_pulse is 1 only for break offsets SYNC_DELAY to SYNC_DELAY+SYNC_TICKS-1.
- R7: cycle_done is 1 for exactly one clock: the clock after the tick that moves the position from CYCLE_TICKS-1 back to 0, which is the end of the measurement window. It is 0 at all other times.
- R8: Neither measure_window nor sync_pulse is ever 1 while charge_on is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_800hz | input | 1 | One-clock time-base enable |
| charge_on | output | 1 | Charging permitted (outside the break) |
| measure_window | output | 1 | Voltage converter may measure |
| sync_pulse | output | 1 | External synchronisation pulse |
| cycle_done | output | 1 | One-clock strobe at the end of the measurement window |

## Verification
The bench builds two copies of the block.

The first is scaled down: a 40-tick period, a 16-tick break, a 6-tick settle, and a 3-tick sync pulse at offset 2. With these values and irregular ticks, many wraps happen in a short run, and the bench can reach every phase edge, the wrap and a reset in the middle of a period.

The second copy uses the default values with a tick on every clock. It checks that the full-size counter wraps after exactly 16384 ticks, and that the break, settle and sync positions decode correctly at their real widths, including a sync window whose end is not a power of two.

// File: rtl/charge_break_sequencer.sv
module charge_break_sequencer #(
  parameter int CYCLE_TICKS  = 16384,
  parameter int BREAK_TICKS  = 2048,
  parameter int SETTLE_TICKS = 1024,
  parameter int SYNC_DELAY   = 32,
  parameter int SYNC_TICKS   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_800hz,
  output logic charge_on,
  output logic measure_window,
  output logic sync_pulse,
  output logic cycle_done
);

  localparam int PW = $clog2(CYCLE_TICKS);
  localparam int XW = PW + 1;
  localparam int BRK_START_I  = CYCLE_TICKS - BREAK_TICKS;
  localparam int MEAS_START_I = BRK_START_I + SETTLE_TICKS;
  localparam int SYNC_START_I = BRK_START_I + SYNC_DELAY;
  localparam int SYNC_END_I   = SYNC_START_I + SYNC_TICKS;

  localparam logic [PW-1:0] LAST       = PW'(CYCLE_TICKS - 1);
  localparam logic [XW-1:0] BRK_START  = XW'(BRK_START_I);
  localparam logic [XW-1:0] MEAS_START = XW'(MEAS_START_I);
  localparam logic [XW-1:0] SYNC_START = XW'(SYNC_START_I);
  localparam logic [XW-1:0] SYNC_END   = XW'(SYNC_END_I);

  if (BREAK_TICKS < 1 || BREAK_TICKS >= CYCLE_TICKS || SETTLE_TICKS >= BREAK_TICKS ||
      SYNC_TICKS < 1 || SYNC_DELAY + SYNC_TICKS > BREAK_TICKS) begin : g_bad_params
    $error("charge_break_sequencer: inconsistent timing parameters");
  end

  logic [PW-1:0] pos;
  logic [XW-1:0] pos_x;
  logic          at_last;

  assign at_last = (pos == LAST);
  assign pos_x   = {1'b0, pos};

  always_ff @(posedge clk) begin
    if (rst) begin
      pos        <= '0;
      cycle_done <= 1'b0;
    end else begin
      cycle_done <= tick_800hz && at_last;
      if (tick_800hz) pos <= at_last ? '0 : pos + 1'b1;
    end
  end

  assign charge_on      = pos_x < BRK_START;
  assign measure_window = pos_x >= MEAS_START;
  assign sync_pulse     = (pos_x >= SYNC_START) && (pos_x < SYNC_END);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tick_800hz |=> $stable(pos));

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_800hz && at_last) |=> (pos == '0));

  p_enter_break_r4: assert property (@(posedge clk) disable iff (rst)
    (tick_800hz && pos_x == BRK_START - 1'b1) |=> !charge_on);

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    cycle_done |=> !cycle_done);

  p_done_after_window_r7: assert property (@(posedge clk) disable iff (rst)
    cycle_done |-> (charge_on && $past(measure_window)));

  p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    charge_on |-> (!measure_window && !sync_pulse));

endmodule

// File: tb/tb_charge_break_sequencer.sv
module tb_charge_break_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int S_CYC = 40, S_BRK = 16, S_SET = 6, S_SD = 2, S_SL = 3;
  localparam int F_CYC = 16384, F_BRK = 2048, F_SET = 1024, F_SD = 32, F_SL = 8;
  localparam int RUN_CLOCKS = 34000;

  logic clk = 0, rst = 1, tick_s = 0, tick_f = 0;
  logic co_s, mw_s, sp_s, cd_s, co_f, mw_f, sp_f, cd_f;
  int checks = 0, errors = 0, clocks = 0;
  int pos_s = 0, pos_f = 0, done_s = 0, done_f = 0;
  int ticks_f = 0, pulses_f = 0;
  logic prev_tick_s = 0, prev_rst = 1;
  logic [2:0] prev_out_s = 3'b100;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  charge_break_sequencer #(.CYCLE_TICKS(S_CYC), .BREAK_TICKS(S_BRK), .SETTLE_TICKS(S_SET),
    .SYNC_DELAY(S_SD), .SYNC_TICKS(S_SL)) dut (
    .clk(clk), .rst(rst), .tick_800hz(tick_s),
    .charge_on(co_s), .measure_window(mw_s), .sync_pulse(sp_s), .cycle_done(cd_s));

  charge_break_sequencer dut_full (
    .clk(clk), .rst(rst), .tick_800hz(tick_f),
    .charge_on(co_f), .measure_window(mw_f), .sync_pulse(sp_f), .cycle_done(cd_f));

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (time %0t)", req, what, got, exp, $time);
    end
  endtask

  // Reference model: updated at the active edge from the inputs driven at the previous falling edge
  always @(posedge clk) begin
    if (rst) begin
      pos_s = 0; pos_f = 0; done_s = 0; done_f = 0;
    end else begin
      done_s = (tick_s && pos_s == S_CYC - 1) ? 1 : 0;
      done_f = (tick_f && pos_f == F_CYC - 1) ? 1 : 0;
      if (tick_s) pos_s = (pos_s + 1) % S_CYC;
      if (tick_f) begin pos_f = (pos_f + 1) % F_CYC; ticks_f++; end
    end
  end

  always @(negedge clk) begin
    int bs, bf;
    clocks++;
    bs = pos_s - (S_CYC - S_BRK);
    bf = pos_f - (F_CYC - F_BRK);
    if (prev_rst) begin
      chk("R1", "reset charge_on", co_s, 1);
      chk("R1", "reset window/sync/done", {mw_s, sp_s, cd_s}, 0);
    end
    if (!prev_rst && !prev_tick_s)
      chk("R2", "outputs held without tick", {co_s, mw_s, sp_s}, prev_out_s);
    chk("R4", "charge_on small", co_s, bs < 0);
    chk("R5", "measure_window small", mw_s, bs >= S_SET);
    chk("R6", "sync_pulse small", sp_s, bs >= S_SD && bs < S_SD + S_SL);
    chk("R7", "cycle_done small", cd_s, done_s);
    chk("R8", "exclusive small", co_s && (mw_s || sp_s), 0);
    chk("R4", "charge_on full", co_f, bf < 0);
    chk("R5", "measure_window full", mw_f, bf >= F_SET);
    chk("R6", "sync_pulse full", sp_f, bf >= F_SD && bf < F_SD + F_SL);
    chk("R7", "cycle_done full", cd_f, done_f);
    if (cd_f) pulses_f++;
    prev_out_s = {co_s, mw_s, sp_s};
    prev_rst = rst;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tick_s = lfsr[0] | lfsr[3];
    prev_tick_s = tick_s;
    tick_f = !rst;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (500) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    repeat (RUN_CLOCKS) @(negedge clk);
    #1;
    chk("R3", "full-size wraps", pulses_f, ticks_f / F_CYC);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * (RUN_CLOCKS + 2000));
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule